// File: doc/BRIEF.md
# Integer Twin Butterfly Rounding Unit

This block is a two-stage pipelined integer datapath for the butterfly step of fixed-point transforms. One accepted operation carries two signed operands `a` and `b`, a signed coefficient `c`, a shift amount `n`, a destination index and two accumulator values. From these it computes two results at once. The sum path gives `acc_p + round((a + b) * c, n)` and the difference path gives `acc_s + round((a - b) * c, n)`. Rounding adds half of the final LSB and then shifts right arithmetically.

The caller reads both destinations before issue and writes back the two results the unit returns. The sum result goes to the named index and the difference result goes to the index one above it. Issuing a second operation with `a` and `b` swapped and a new coefficient, with the first results as accumulators, completes a two-coefficient butterfly.

An operation with the record bit set writes nothing and is reported as illegal. Operations enter and leave under a valid/ready handshake, and the pipeline can take one operation per cycle.

Top module: `twin_bfly_unit`

## Requirements
- R1: For a legal operation, `out_sum` equals `in_acc_p + round((a+b)*c)` modulo 2^64.
- R2: For a legal operation, `out_dif` equals `in_acc_s + round((a-b)*c)` modulo 2^64.
- R3: For n in 1..63, round(x) = floor((x + 2^(n-1)) / 2^n), an arithmetic shift, so a negative value exactly at half goes toward plus infinity (for example -3 with n=1 gives -1).
- R4: With n = 0, no rounding constant is added and the product passes through unshifted.
- R5: The sum and difference are formed at 33 bits and the product at 65 bits, so a=b=0x7FFFFFFF with c=0x80000000 gives the exact product.
- R6: Accumulation wraps modulo 2^64 with no saturation.
- R7: `out_dst_p` repeats the issued index and `out_dst_s` is that index plus one, modulo 32 (index 31 pairs with 0).
- R8: With `in_rec`=1 the result appears with `out_wen`=0 and `out_illegal`=1. A legal result has `out_wen`=1 and `out_illegal`=0.
- R9: An operation accepted at a clock edge gives `out_valid`=1 after the second following edge. With `out_ready` held at 1, one operation is accepted on every edge.
- R10: While `out_valid`=1 and `out_ready`=0, all outputs hold steady and `in_ready` is 0. Results leave in issue order with none lost or repeated.
- R11: Issuing (a,b,c1) and then (b,a,c2), with the first pair of results as accumulators, yields `round((a+b)c1)+round((a+b)c2)` at the primary index and `round((a-b)c1)+round((b-a)c2)` at the paired index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted on this edge when valid |
| in_a | input | 32 | Signed operand a |
| in_b | input | 32 | Signed operand b |
| in_c | input | 32 | Signed coefficient |
| in_shift | input | 6 | Shift amount n |
| in_dst | input | 5 | Primary destination index |
| in_rec | input | 1 | Record bit; 1 makes the operation illegal |
| in_acc_p | input | 64 | Current content of the primary destination |
| in_acc_s | input | 64 | Current content of the paired destination |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_sum | output | 64 | New value for the primary destination |
| out_dif | output | 64 | New value for the paired destination |
| out_dst_p | output | 5 | Primary destination index |
| out_dst_s | output | 5 | Paired destination index |
| out_wen | output | 1 | Write both destinations |
| out_illegal | output | 1 | Illegal-instruction indication |

## Verification
The case of interest is a back-pressure stall that lands in the same cycle as a new operation being offered. The input must then be refused while the held result stays frozen. The bench provokes this by toggling `out_ready` pseudo-randomly while a burst of operations keeps `in_valid` high, mixing in illegal operations and wrap-around indices. A scoreboard queue judges the run: every result must match its expected item in issue order, and every stalled cycle is compared with the cycle before it.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int NPATH = 2;
  typedef enum int {PATH_SUM = 0, PATH_DIF = 1} path_e;
endpackage

// File: rtl/twb_prod.sv
module twb_prod #(
  parameter int OPW = 32,
  parameter int PW  = 2 * OPW + 1
) (
  input  logic [OPW-1:0]        a,
  input  logic [OPW-1:0]        b,
  input  logic [OPW-1:0]        c,
  output logic signed [PW-1:0]  p_sum,
  output logic signed [PW-1:0]  p_dif
);
  logic signed [OPW:0]   s_ext, d_ext;
  logic signed [PW-1:0]  s_w, d_w, c_w;

  always_comb begin
    s_ext = $signed({a[OPW-1], a}) + $signed({b[OPW-1], b});
    d_ext = $signed({a[OPW-1], a}) - $signed({b[OPW-1], b});
    s_w   = PW'(s_ext);
    d_w   = PW'(d_ext);
    c_w   = PW'($signed(c));
    p_sum = s_w * c_w;
    p_dif = d_w * c_w;
  end
endmodule

// File: rtl/twb_round.sv
module twb_round #(
  parameter int PW  = 65,
  parameter int ACW = 64,
  parameter int SHW = 6
) (
  input  logic signed [PW-1:0] prod,
  input  logic [SHW-1:0]       shamt,
  input  logic [ACW-1:0]       acc,
  output logic [ACW-1:0]       res
);
  localparam int EW = (PW + 1 > ACW) ? PW + 1 : ACW;

  logic signed [EW-1:0] ext;
  logic [EW-1:0] one, half, biased, keep, shr, smask, val;

  always_comb begin
    ext    = EW'(prod);
    one    = {{(EW-1){1'b0}}, 1'b1};
    half   = (shamt == '0) ? '0 : (one << (shamt - 1'b1));
    biased = ext + half;
    keep   = {EW{1'b1}} >> shamt;
    shr    = (biased >> shamt) & keep;
    smask  = biased[EW-1] ? ~keep : '0;
    val    = shr | smask;
    res    = val[ACW-1:0] + acc;
  end
endmodule

// File: rtl/twb_pair_dec.sv
module twb_pair_dec #(
  parameter int IDXW = 5
) (
  input  logic [IDXW-1:0] prim,
  output logic [IDXW-1:0] pair
);
  always_comb pair = prim + {{(IDXW-1){1'b0}}, 1'b1};
endmodule

// File: rtl/twin_bfly_unit.sv
module twin_bfly_unit #(
  parameter int OPW  = 32,
  parameter int ACW  = 64,
  parameter int IDXW = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OPW-1:0]        in_a,
  input  logic [OPW-1:0]        in_b,
  input  logic [OPW-1:0]        in_c,
  input  logic [$clog2(ACW)-1:0] in_shift,
  input  logic [IDXW-1:0]       in_dst,
  input  logic                  in_rec,
  input  logic [ACW-1:0]        in_acc_p,
  input  logic [ACW-1:0]        in_acc_s,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ACW-1:0]        out_sum,
  output logic [ACW-1:0]        out_dif,
  output logic [IDXW-1:0]       out_dst_p,
  output logic [IDXW-1:0]       out_dst_s,
  output logic                  out_wen,
  output logic                  out_illegal
);
  import twb_pkg::*;
  localparam int SHW = $clog2(ACW);
  localparam int PW  = 2 * OPW + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_ok_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q  <= 1'b0;
      rst_ok_q <= 1'b0;
    end else begin
      rst_m_q  <= 1'b1;
      rst_ok_q <= rst_m_q;
    end
  end

  // stage 1 datapath
  logic signed [PW-1:0] p_sum_c, p_dif_c;
  twb_prod #(.OPW(OPW), .PW(PW)) i_prod (
    .a(in_a), .b(in_b), .c(in_c), .p_sum(p_sum_c), .p_dif(p_dif_c)
  );

  logic                  s1_vld_q, s1_vld_d;
  logic signed [PW-1:0]  s1_prod_q [NPATH];
  logic [ACW-1:0]        s1_acc_q  [NPATH];
  logic [SHW-1:0]        s1_sh_q;
  logic [IDXW-1:0]       s1_dst_q;
  logic                  s1_rec_q;

  // stage 2 (output) registers
  logic                  o_vld_q, o_vld_d;
  logic [ACW-1:0]        o_res_q [NPATH];
  logic [IDXW-1:0]       o_dp_q, o_ds_q;
  logic                  o_rec_q;

  logic adv, take;
  always_comb begin
    adv      = !o_vld_q || out_ready;
    take     = in_valid && adv && rst_ok_q;
    s1_vld_d = adv ? take : s1_vld_q;
    o_vld_d  = adv ? s1_vld_q : o_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      o_vld_q  <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      o_vld_q  <= o_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      s1_prod_q[PATH_SUM] <= p_sum_c;
      s1_prod_q[PATH_DIF] <= p_dif_c;
      s1_acc_q[PATH_SUM]  <= in_acc_p;
      s1_acc_q[PATH_DIF]  <= in_acc_s;
      s1_sh_q             <= in_shift;
      s1_dst_q            <= in_dst;
      s1_rec_q            <= in_rec;
    end
  end

  // stage 2 datapath: one rounding/accumulate lane per path
  logic [ACW-1:0] res_c [NPATH];
  for (genvar g = 0; g < NPATH; g++) begin : g_lane
    twb_round #(.PW(PW), .ACW(ACW), .SHW(SHW)) i_round (
      .prod(s1_prod_q[g]), .shamt(s1_sh_q), .acc(s1_acc_q[g]), .res(res_c[g])
    );
  end

  logic [IDXW-1:0] pair_c;
  twb_pair_dec #(.IDXW(IDXW)) i_pair (.prim(s1_dst_q), .pair(pair_c));

  logic o_load;
  always_comb o_load = adv && s1_vld_q;

  always_ff @(posedge clk) begin
    if (o_load) begin
      o_res_q[PATH_SUM] <= res_c[PATH_SUM];
      o_res_q[PATH_DIF] <= res_c[PATH_DIF];
      o_dp_q            <= s1_dst_q;
      o_ds_q            <= pair_c;
      o_rec_q           <= s1_rec_q;
    end
  end

  always_comb begin
    in_ready    = adv && rst_ok_q;
    out_valid   = o_vld_q;
    out_sum     = o_res_q[PATH_SUM];
    out_dif     = o_res_q[PATH_DIF];
    out_dst_p   = o_dp_q;
    out_dst_s   = o_ds_q;
    out_wen     = o_vld_q && !o_rec_q;
    out_illegal = o_vld_q && o_rec_q;
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum) && $stable(out_dif)
      && $stable(out_dst_p) && $stable(out_wen));
  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R8
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_wen && out_valid);
  // R7
  pair_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_dst_s == IDXW'(out_dst_p + 1'b1));
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> ##2 out_valid);
endmodule

// File: tb/test_twin_bfly_unit.sv
module test_twin_bfly_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [31:0] in_a, in_b, in_c;
  logic [5:0]  in_shift;
  logic [4:0]  in_dst;
  logic        in_rec;
  logic [63:0] in_acc_p, in_acc_s;
  logic        out_valid, out_ready;
  logic [63:0] out_sum, out_dif;
  logic [4:0]  out_dst_p, out_dst_s;
  logic        out_wen, out_illegal;

  always #5 clk = ~clk;

  twin_bfly_unit i_twin_bfly_unit (.*);

  typedef struct {
    logic [63:0] sum, dif;
    logic [4:0]  dp, ds;
    logic        ill;
    string       req;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  logic stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [63:0] rnd(input logic signed [64:0] p, input int n);
    logic signed [65:0] t;
    t = p;
    if (n > 0) t = t + (66'sd1 <<< (n - 1));
    t = t >>> n;
    return t[63:0];
  endfunction

  function automatic logic signed [64:0] mulx(input logic [31:0] x, input logic [31:0] y,
                                              input logic [31:0] c, input bit sub);
    logic signed [32:0] s;
    logic signed [64:0] r;
    if (sub) s = $signed(x) - $signed(y);
    else     s = $signed(x) + $signed(y);
    r = s * $signed(c);
    return r;
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                      input int n, input logic [4:0] d, input logic rec,
                      input logic [63:0] ap, input logic [63:0] as_, input string req);
    exp_t e;
    e.sum = ap  + rnd(mulx(a, b, c, 1'b0), n);
    e.dif = as_ + rnd(mulx(a, b, c, 1'b1), n);
    e.dp  = d;
    e.ds  = d + 5'd1;
    e.ill = rec;
    e.req = req;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_shift = 6'(n);
    in_dst = d; in_rec = rec; in_acc_p = ap; in_acc_s = as_;
    #4;
    while (!in_ready) begin
      @(negedge clk);
      #4;
    end
    @(posedge clk);
    q.push_back(e);
    #1 in_valid = 1'b0;
  endtask

  // ready pattern
  always @(negedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  logic        held = 1'b0;
  logic [63:0] h_sum, h_dif;
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      if (held) begin
        chk(out_valid === 1'b1, "R10 valid held", {63'd0, out_valid}, 64'd1);
        chk(out_sum === h_sum && out_dif === h_dif, "R10 data held", out_sum, h_sum);
      end
      held = 1'b0;
      if (out_valid && !out_ready) begin
        chk(in_ready === 1'b0, "R10 in_ready low in stall", {63'd0, in_ready}, 64'd0);
        held = 1'b1; h_sum = out_sum; h_dif = out_dif;
      end
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R10 unexpected result", out_sum, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(out_illegal === e.ill && out_wen === !e.ill, {"R8 flags ", e.req},
              {62'd0, out_wen, out_illegal}, {62'd0, !e.ill, e.ill});
          chk(out_dst_p === e.dp && out_dst_s === e.ds, {"R7 index pair ", e.req},
              {54'd0, out_dst_p, out_dst_s}, {54'd0, e.dp, e.ds});
          if (!e.ill) begin
            chk(out_sum === e.sum, {"R1 sum ", e.req}, out_sum, e.sum);
            chk(out_dif === e.dif, {"R2 dif ", e.req}, out_dif, e.dif);
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic drain;
    int guard = 0;
    while ((q.size() != 0 || out_valid) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [63:0] r1p, r1s;
    in_valid = 1'b0; in_a = '0; in_b = '0; in_c = '0; in_shift = '0;
    in_dst = '0; in_rec = 1'b0; in_acc_p = '0; in_acc_s = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R9 ready after reset", {63'd0, in_ready}, 64'd1);

    // R9 latency: accept, then one empty cycle, then valid
    send(32'd10, 32'd4, 32'd3, 1, 5'd2, 1'b0, 64'd0, 64'd0, "R9");
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 not yet valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R9 valid after two edges", {63'd0, out_valid}, 64'd1);
    drain();

    // R3 rounding at exact half, negative and positive
    send(32'hFFFF_FFFF, 32'd0, 32'd3, 1, 5'd4, 1'b0, 64'd0, 64'd0, "R3 neg half");
    send(32'd1, 32'd0, 32'd3, 1, 5'd6, 1'b0, 64'd0, 64'd0, "R3 pos half");
    send(32'd1000, 32'hFFFF_F000, 32'h8000_0001, 13, 5'd8, 1'b0, 64'd5, 64'd7, "R3 n13");
    // R4 n = 0
    send(32'd7, 32'd2, 32'hFFFF_FFFD, 0, 5'd10, 1'b0, 64'd100, 64'd200, "R4");
    // R5 no overflow before multiply
    send(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 0, 5'd12, 1'b0, 64'd0, 64'd0, "R5 max");
    send(32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 63, 5'd14, 1'b0, 64'd0, 64'd0, "R5 n63");
    // R6 wrap
    send(32'd5, 32'd3, 32'd2, 0, 5'd16, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF,
         64'hFFFF_FFFF_FFFF_FFFF, "R6 wrap");
    // R7 index 31 pairs with 0
    send(32'd1, 32'd1, 32'd1, 0, 5'd31, 1'b0, 64'd0, 64'd0, "R7 wrap idx");
    // R8 record bit
    send(32'd9, 32'd9, 32'd9, 2, 5'd20, 1'b1, 64'd1, 64'd2, "R8 illegal");
    drain();

    // R11 two-coefficient butterfly by swapped re-issue
    r1p = rnd(mulx(32'd12345, 32'hFFFF_F00F, 32'd2896, 1'b0), 12);
    r1s = rnd(mulx(32'd12345, 32'hFFFF_F00F, 32'd2896, 1'b1), 12);
    send(32'd12345, 32'hFFFF_F00F, 32'd2896, 12, 5'd22, 1'b0, 64'd0, 64'd0, "R11 first");
    send(32'hFFFF_F00F, 32'd12345, 32'd1567, 12, 5'd22, 1'b0, r1p, r1s, "R11 second");
    drain();
    chk(r1p + rnd(mulx(32'd12345, 32'hFFFF_F00F, 32'd1567, 1'b0), 12) ==
        rnd(mulx(32'hFFFF_F00F, 32'd12345, 32'd1567, 1'b0), 12) + r1p,
        "R11 sum symmetry", r1p, r1p);

    // R10 back-pressure with a continuous stream
    stall_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      send(32'(i * 7919 - 50000), 32'(i * 104729), 32'(32'h1234_5 - i * 333),
           (i * 5) % 64, 5'(i), (i % 9) == 4, 64'(i) << 40, 64'(-i), "R10 stream");
    end
    stall_en = 1'b0;
    drain();
    chk(q.size() == 0, "R10 all results delivered", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule